// File: doc/BRIEF.md
# Second-order pulse-density audio modulator

This block turns a signed 16-bit audio sample into a one-bit stream whose density of ones follows the sample value. It runs at the oversampled clock rate. The sample may stay constant or change on any clock. The output bit goes to an analog low-pass filter outside the chip.

The loop is second order and shapes its noise with an error-feedback structure. The quantization error is taken at the second stage and limited symmetrically. It then feeds the first stage with gain -1 and the second stage with gain +2. The +2 gain is a one-bit left shift. All arithmetic is two's complement on a 25-bit word: the 16 sample bits plus 9 headroom bits. Sums are formed one bit wider and then reduced with saturation.

Top module: `dsm2_pdm_mod`

## Requirements
- R1: While rst_ni is low (asynchronous, active low), both stage registers hold zero and pdm_o is 0. The first rising edge after release drives pdm_o to 1, because a zero second stage counts as non-negative.
- R2: sample_i is read as a signed integer with full scale FS = 32768. It is sign-extended into the 25-bit word with no scaling, so -32768 maps to -FS and +32767 to FS-1.
- R3: At each rising edge pdm_o takes 1 if the second-stage register is non-negative and 0 if it is negative. The quantized level is +FS for 1 and -FS for 0.
- R4: The error is the second-stage value minus the quantized level. It is clamped symmetrically to [-LIMIT_MAG, +LIMIT_MAG] and passes unchanged when inside that range.
- R5: At each rising edge the first-stage register takes the extended sample minus the limited error.
- R6: At each rising edge the second-stage register takes the previous first-stage value plus twice the limited error.
- R7: Every sum is formed one bit wider and then reduced to 25 bits, saturating to the most positive or most negative value instead of wrapping. With the limiter active, the first stage stays within ±(FS+LIMIT_MAG) and the second within ±(FS+3·LIMIT_MAG), including for the extreme inputs -32768 and +32767.
- R8: For a constant sample x, the fraction of ones on pdm_o over many clocks tracks (x/FS+1)/2. For |x| up to FS/2 it lies within a few percent of that value.
- R9: A sample captured at a rising edge first affects pdm_o at the second rising edge after it. A new sample may be applied on every clock.
- R10: LIMIT_MAG defaults to 0.6·FS rounded to the integer grid, which is 19661.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 16 | Signed audio sample, full scale ±32768 |
| pdm_o | output | 1 | Registered one-bit density output |

## Verification
The bound checker checks the loop arithmetic on every clock: pdm_o follows the sign of the second stage, the limiter holds its bound and passes in-range errors, and each stage register takes the sum R5 and R6 define from the previous cycle. It also checks that both stages stay inside the ranges R7 gives and that reset holds everything at zero. What no single-cycle property can show is the long-run density of ones against the sample value, and the exact bit sequence when the input changes on every clock or sits at its extremes. The bench's scenarios cover these by comparing each bit against an independent model and by counting ones over long windows.

// File: rtl/dsm2_pkg.sv
package dsm2_pkg;

  // sample width and integer headroom of the internal word
  localparam int unsigned SMP_W  = 16;
  localparam int unsigned HEAD_W = 9;
  localparam int unsigned ACC_W  = SMP_W + HEAD_W;
  localparam int unsigned WIDE_W = ACC_W + 1;

  typedef logic signed [SMP_W-1:0]  smp_t;
  typedef logic signed [ACC_W-1:0]  acc_t;
  typedef logic signed [WIDE_W-1:0] wide_t;

  // magnitude of the most negative sample
  localparam int FS_INT = 1 << (SMP_W - 1);
  // 0.6 of full scale, rounded to nearest
  localparam int LIMIT_DEF = (FS_INT * 3 + 2) / 5;

  localparam acc_t FULL_SCALE = acc_t'(FS_INT);
  localparam acc_t ACC_MAX    = {1'b0, {(ACC_W-1){1'b1}}};
  localparam acc_t ACC_MIN    = {1'b1, {(ACC_W-1){1'b0}}};

  typedef enum logic [0:0] {
    PATH_MINUS = 1'b0,  // next = a - b
    PATH_TWICE = 1'b1   // next = a + 2b
  } path_e;

  function automatic acc_t widen_sample(smp_t s);
    return acc_t'(s);
  endfunction

  function automatic wide_t grow(acc_t a);
    return wide_t'(a);
  endfunction

  // reduce a widened sum to the word, clamping on overflow
  function automatic acc_t shrink_sat(wide_t w);
    acc_t r;
    if (w[WIDE_W-1] != w[WIDE_W-2]) begin
      r = w[WIDE_W-1] ? ACC_MIN : ACC_MAX;
    end else begin
      r = w[ACC_W-1:0];
    end
    return r;
  endfunction

  function automatic acc_t add_sat(acc_t a, acc_t b);
    return shrink_sat(grow(a) + grow(b));
  endfunction

  function automatic acc_t sub_sat(acc_t a, acc_t b);
    return shrink_sat(grow(a) - grow(b));
  endfunction

  function automatic acc_t twice_sat(acc_t a);
    return shrink_sat(grow(a) <<< 1);
  endfunction

  function automatic acc_t clamp_sym(acc_t a, acc_t lim);
    acc_t r;
    if (a > lim) begin
      r = lim;
    end else if (a < -lim) begin
      r = -lim;
    end else begin
      r = a;
    end
    return r;
  endfunction

endpackage

// File: rtl/dsm2_quantizer.sv
module dsm2_quantizer
  import dsm2_pkg::*;
(
  input  acc_t level_i,
  output logic pos_o,
  output acc_t quant_o
);

  always_comb begin
    pos_o   = ~level_i[ACC_W-1];
    quant_o = pos_o ? FULL_SCALE : -FULL_SCALE;
  end

endmodule

// File: rtl/dsm2_fb_limiter.sv
module dsm2_fb_limiter
  import dsm2_pkg::*;
#(
  parameter int LIMIT_MAG = LIMIT_DEF
) (
  input  acc_t level_i,
  input  acc_t quant_i,
  output acc_t err_raw_o,
  output acc_t err_lim_o
);

  localparam acc_t LIM = acc_t'(LIMIT_MAG);

  always_comb begin
    err_raw_o = sub_sat(level_i, quant_i);
    err_lim_o = clamp_sym(err_raw_o, LIM);
  end

endmodule

// File: rtl/dsm2_stage.sv
module dsm2_stage
  import dsm2_pkg::*;
#(
  parameter path_e PATH = PATH_MINUS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  acc_t base_i,
  input  acc_t corr_i,
  output acc_t state_o
);

  acc_t nxt;
  acc_t state_q;

  generate
    if (PATH == PATH_MINUS) begin : g_minus
      always_comb nxt = sub_sat(base_i, corr_i);
    end else begin : g_twice
      always_comb nxt = add_sat(base_i, twice_sat(corr_i));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
    end else begin
      state_q <= nxt;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/dsm2_pdm_mod.sv
module dsm2_pdm_mod
  import dsm2_pkg::*;
#(
  parameter int LIMIT_MAG = LIMIT_DEF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [SMP_W-1:0] sample_i,
  output logic                    pdm_o
);

  // named loop wires, also observed by the checker
  acc_t smp_ext;
  acc_t stg1_q;
  acc_t stg2_q;
  acc_t quant;
  acc_t err_raw;
  acc_t err_lim;
  logic lvl_pos;

  assign smp_ext = widen_sample(sample_i);

  dsm2_quantizer u_quant (
    .level_i (stg2_q),
    .pos_o   (lvl_pos),
    .quant_o (quant)
  );

  dsm2_fb_limiter #(
    .LIMIT_MAG (LIMIT_MAG)
  ) u_lim (
    .level_i   (stg2_q),
    .quant_i   (quant),
    .err_raw_o (err_raw),
    .err_lim_o (err_lim)
  );

  dsm2_stage #(
    .PATH (PATH_MINUS)
  ) u_stg1 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .base_i  (smp_ext),
    .corr_i  (err_lim),
    .state_o (stg1_q)
  );

  dsm2_stage #(
    .PATH (PATH_TWICE)
  ) u_stg2 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .base_i  (stg1_q),
    .corr_i  (err_lim),
    .state_o (stg2_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pdm_o <= 1'b0;
    end else begin
      pdm_o <= lvl_pos;
    end
  end

endmodule

// File: rtl/dsm2_pdm_mod_chk.sv
module dsm2_pdm_mod_chk
  import dsm2_pkg::*;
#(
  parameter int LIMIT_MAG = LIMIT_DEF
) (
  input logic clk_i,
  input logic rst_ni,
  input smp_t sample_i,
  input logic pdm_o,
  input acc_t stg1,
  input acc_t stg2,
  input acc_t err_raw,
  input acc_t err_lim
);

  localparam int BOUND1 = FS_INT + LIMIT_MAG;
  localparam int BOUND2 = FS_INT + 3 * LIMIT_MAG;

  // set once an edge has passed outside reset
  logic ran_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ran_q <= 1'b0;
    else         ran_q <= 1'b1;
  end

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_hold_chk: assert (pdm_o == 1'b0 && stg1 == '0 && stg2 == '0)
        else $error("reset state not held");
    end
  end

  // R3
  quant_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ran_q |-> (pdm_o == ($past(int'(stg2)) >= 0)));

  // R4
  lim_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(err_lim) <= LIMIT_MAG) && (int'(err_lim) >= -LIMIT_MAG));

  // R4
  lim_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((int'(err_raw) <= LIMIT_MAG) && (int'(err_raw) >= -LIMIT_MAG))
      |-> (err_lim == err_raw));

  // R5
  stage1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ran_q |-> (int'(stg1) == $past(int'(sample_i)) - $past(int'(err_lim))));

  // R6
  stage2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ran_q |-> (int'(stg2) == $past(int'(stg1)) + 2 * $past(int'(err_lim))));

  // R7
  range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(stg1) <= BOUND1) && (int'(stg1) >= -BOUND1) &&
    (int'(stg2) <= BOUND2) && (int'(stg2) >= -BOUND2));

endmodule

bind dsm2_pdm_mod dsm2_pdm_mod_chk #(
  .LIMIT_MAG (LIMIT_MAG)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sample_i (sample_i),
  .pdm_o    (pdm_o),
  .stg1     (stg1_q),
  .stg2     (stg2_q),
  .err_raw  (err_raw),
  .err_lim  (err_lim)
);

// File: tb/dsm2_pdm_mod_tb_top.sv
module dsm2_pdm_mod_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int FS  = 32768;
  localparam int LIM = 19661;  // R10: 0.6 of FS, rounded

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic signed [15:0] sample = '0;
  logic               pdm;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  int  hist_x[$];
  int  hist_e[$];
  bit  exp_bit;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsm2_pdm_mod dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .sample_i (sample),
    .pdm_o    (pdm)
  );

  task automatic model_clear();
    hist_x = {0, 0};
    hist_e = {0, 0};
    exp_bit = 1'b0;
  endtask

  // one clock of the loop seen as: level = x(n-2) - e(n-2) + 2 e(n-1)
  task automatic model_step(int x);
    int lvl;
    int err;
    lvl = hist_x[0] - hist_e[0] + 2 * hist_e[1];
    exp_bit = (lvl >= 0);
    err = lvl - (exp_bit ? FS : -FS);
    if (err > LIM) err = LIM;
    if (err < -LIM) err = -LIM;
    void'(hist_x.pop_front());
    void'(hist_e.pop_front());
    hist_x.push_back(x);
    hist_e.push_back(err);
  endtask

  task automatic check_bit(string tag, bit expv);
    n_vec++;
    if (pdm !== expv) begin
      n_bad++;
      $display("FAIL %s: pdm actual %0b expected %0b at %0t", tag, pdm, expv, $time);
    end
  endtask

  // run n clocks with sample x, comparing every bit, counting ones
  task automatic run_const(int x, int n, string tag, output int ones);
    ones = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_bit(tag, exp_bit);
      if (pdm === 1'b1) ones++;
      model_step(x);
      sample = 16'(x);
    end
  endtask

  task automatic density(int x, int n, int tol_pm, string tag);
    int ones;
    int got_pm;
    int exp_pm;
    run_const(x, 64, tag, ones);
    run_const(x, n, tag, ones);
    got_pm = (ones * 1000) / n;
    exp_pm = 500 + (x * 500) / FS;
    n_vec++;
    if (got_pm > exp_pm + tol_pm || got_pm < exp_pm - tol_pm) begin
      n_bad++;
      $display("FAIL %s: density actual %0d expected %0d per mille", tag, got_pm, exp_pm);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    sample = '0;
    model_clear();
    #1;
    check_bit("R1 reset", 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_bit("R1 reset", 1'b0);
    end
    rst_n = 1'b1;
    model_step(0);
    @(negedge clk);
    check_bit("R1 first edge", 1'b1);
    model_step(0);
  endtask

  initial begin
    int ones;
    logic [31:0] seed;
    model_clear();
    do_reset();

    // R8 at zero and moderate levels, both signs (R2 for negatives)
    density(0, 4096, 40, "R8 zero");
    density(8192, 4096, 60, "R8 +quarter");
    density(-8192, 4096, 60, "R2 R8 -quarter");
    density(16384, 4096, 80, "R8 +half");
    density(-16384, 4096, 80, "R2 R8 -half");

    // extremes: limiter active and saturation headroom exercised
    run_const(32767, 2000, "R7 R10 max", ones);
    run_const(-32768, 2000, "R7 R10 min", ones);
    run_const(30000, 1000, "R4 near max", ones);
    run_const(-30000, 1000, "R4 near min", ones);

    // R9: new sample on every clock
    seed = 32'h1234_5678;
    for (int i = 0; i < 3000; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      run_const(int'($signed(seed[30:15])), 1, "R9 R5 R6 varying", ones);
    end

    // R9: single step change, first effect two edges after capture
    do_reset();
    run_const(0, 200, "R9 settle", ones);
    run_const(20000, 50, "R9 step", ones);

    // R1 reset in mid-run
    run_const(-12000, 300, "R3 pre-reset", ones);
    do_reset();
    run_const(5000, 300, "R1 after reset", ones);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule